// File: doc/BRIEF.md
# Incremental ADC Count Accumulator

This block is the digital back end of an integrating, incremental ADC. While a conversion runs, each cycle in which the comparator-gated count enable is high is counted. An 8-bit down counter carries a 16-bit extension word, and each time the low counter wraps, the extension word is bumped.

When the integration timer marks the end of an integrate period, the block freezes the count and folds in the residual low byte. It clamps an out-of-range value, divides by four and publishes a 16-bit result. It then raises a sticky ready flag and re-arms for the next period in the same cycle.

A sample count given at start selects how the block runs. Zero means convert forever. Any other value means stop after that many results. When stopped, the block drops the run enable to the timer and holds the integrator in reset.

The analog side is reached only through two level outputs, integrator reset and auto-zero.

Top module: `incadc_accum`

## Requirements
- R1: While `rst_ni` is low and after its release, `result_o` is 0, `ready_o` is 0, `run_o` is 0 and `int_rst_o` is 1.
- R2: A cycle with `start_i` high sets up the next cycle as follows: `run_o` is 1, `ready_o` is 0 and `int_rst_o` is 0. The low counter is 0xFF and the extension word holds the preset for the current format.
- R3: In unsigned format (`signed_i`=0), N counted ticks give `result_o` = (N+1)>>2. A tick is a cycle with `gate_i` high, with the block running and no period strobe. `gate_i` in the strobe cycle, or while stopped, adds nothing.
- R4: The low counter wraps from 0x00 to 0xFF every 256 ticks and carries one into the extension word. Counts just below, at and above multiples of 256 therefore still follow R3 and R5.
- R5: In signed format (`signed_i`=1), the extension word presets to 0xFF80. The 24-bit sum A = 0xFF8000+N+1 is shifted arithmetically right by two, and `result_o` is its low 16 bits (A[17:2]).
- R6: Overflow clamp. In unsigned format, if bit 16 of N+1 is set, `result_o` is 0x3FFF. In signed format, if A[23]=0 and A[15]=1, `result_o` is 0x1FFF.
- R7: `result_o` and `ready_o` change in the cycle after a period strobe and at no other time, except that start and clear drop `ready_o`. `ready_o` stays high until cleared.
- R8: `int_rst_o` is high for exactly the one cycle after a strobe that does not end the run. `az_o` equals `int_rst_o` when `az_off_i`=1 and is 0 otherwise.
- R9: With a sample count K>0, after the K-th result `run_o` goes to 0 and `int_rst_o` stays at 1.
- R10: With a sample count of 0, `run_o` stays 1 across any number of results.
- R11: `ready_clr_i` lowers `ready_o` on the next cycle. A period strobe while stopped changes neither `result_o` nor `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load sample count, clear ready, arm and run |
| samp_cnt_i | input | 8 | Conversions to run; 0 selects continuous |
| signed_i | input | 1 | Result format: 1 signed, 0 unsigned |
| az_off_i | input | 1 | Auto-zero configured off; drive auto-zero with integrator reset |
| gate_i | input | 1 | Comparator-gated count enable |
| period_i | input | 1 | End-of-integrate strobe from the timer |
| ready_clr_i | input | 1 | Clear the ready flag |
| result_o | output | 16 | Scaled, clamped conversion result |
| ready_o | output | 1 | Sticky result-ready flag |
| run_o | output | 1 | Run enable for the integration timer |
| int_rst_o | output | 1 | Integrator reset |
| az_o | output | 1 | Integrator auto-zero |

## Verification
Every output is registered, so the effect of an input is due at the first sampling point after the edge that captures it. The bench drives and samples on the falling edge. The result and ready flag are read on the falling edge right after the clock edge that took the period strobe, and that same sample must show the one-cycle integrator reset pulse. The pulse's fall is checked on the next falling edge. Start, clear and stop effects are likewise read one falling edge after their stimulus.

// File: rtl/incadc_pkg.sv
package incadc_pkg;
  typedef enum logic [0:0] {FMT_UNS = 1'b0, FMT_SGN = 1'b1} fmt_e;
  localparam int unsigned SCALE_SH_DEF = 2;
endpackage

// File: rtl/incadc_ext_cnt.sv
module incadc_ext_cnt #(
  parameter int unsigned LOW_W = 8,
  parameter int unsigned UP_W  = 2 * LOW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [UP_W-1:0]  preset_i,
  input  logic             cnt_en_i,
  output logic [LOW_W-1:0] low_o,
  output logic [UP_W-1:0]  up_o
);
  logic [LOW_W-1:0] low_q;
  logic [UP_W-1:0]  up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '1;
      up_q  <= '0;
    end else if (arm_i) begin
      low_q <= '1;
      up_q  <= preset_i;
    end else if (cnt_en_i) begin
      if (low_q == '0) begin
        low_q <= '1;
        up_q  <= up_q + UP_W'(1);
      end else begin
        low_q <= low_q - LOW_W'(1);
      end
    end
  end

  assign low_o = low_q;
  assign up_o  = up_q;

  AST_WRAP_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !arm_i && low_q == '0) |=> (up_q == $past(up_q) + UP_W'(1))); // R4
  AST_ARM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (low_q == {LOW_W{1'b1}})); // R2
endmodule

// File: rtl/incadc_fmt.sv
module incadc_fmt
  import incadc_pkg::*;
#(
  parameter int unsigned LOW_W    = 8,
  parameter int unsigned UP_W     = 2 * LOW_W,
  parameter int unsigned RES_W    = 2 * LOW_W,
  parameter int unsigned SCALE_SH = SCALE_SH_DEF
) (
  input  logic [LOW_W-1:0] low_i,
  input  logic [UP_W-1:0]  up_i,
  input  logic             signed_i,
  output logic [RES_W-1:0] res_o
);
  localparam int unsigned ACC_W = UP_W + LOW_W;

  logic             borrow;
  logic [LOW_W-1:0] lsb_v;
  logic [UP_W-1:0]  up_adj;
  logic [LOW_W-1:0] ext_v;
  logic [LOW_W-1:0] mid_v;
  logic             ovf;
  logic signed [ACC_W-1:0] acc_s;

  // residual: ~(low-1), borrow carries into the extension word
  assign borrow = (low_i == '0);
  assign lsb_v  = ~(low_i - LOW_W'(1));
  assign up_adj = up_i + UP_W'(borrow);
  assign ext_v  = up_adj[UP_W-1:LOW_W];
  assign mid_v  = up_adj[LOW_W-1:0];

  always_comb begin
    if (fmt_e'(signed_i) == FMT_SGN) ovf = ~ext_v[LOW_W-1] & mid_v[LOW_W-1];
    else                             ovf = ext_v[0];
    if (!ovf)
      acc_s = {ext_v, mid_v, lsb_v};
    else if (fmt_e'(signed_i) == FMT_SGN)
      acc_s = {{LOW_W{1'b0}}, 1'b0, {(RES_W-1){1'b1}}};
    else
      acc_s = {{LOW_W{1'b0}}, {RES_W{1'b1}}};
  end

  assign res_o = RES_W'(acc_s >>> SCALE_SH);
endmodule

// File: rtl/incadc_ctrl.sv
module incadc_ctrl #(
  parameter int unsigned SAMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SAMP_W-1:0] samp_cnt_i,
  input  logic              period_i,
  input  logic              ready_clr_i,
  output logic              conv_o,
  output logic              run_o,
  output logic              ready_o,
  output logic              int_rst_o
);
  logic              run_q, ready_q, pulse_q;
  logic [SAMP_W-1:0] left_q;
  logic              conv;
  logic              last;

  assign conv = run_q & period_i & ~start_i;
  assign last = (left_q == SAMP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      ready_q <= 1'b0;
      pulse_q <= 1'b0;
      left_q  <= '0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      ready_q <= 1'b0;
      pulse_q <= 1'b0;
      left_q  <= samp_cnt_i;
    end else begin
      pulse_q <= conv;
      if (conv) begin
        ready_q <= 1'b1;
        if (left_q != '0) left_q <= left_q - SAMP_W'(1);
        if (last) run_q <= 1'b0;
      end else if (ready_clr_i) begin
        ready_q <= 1'b0;
      end
    end
  end

  assign conv_o    = conv;
  assign run_o     = run_q;
  assign ready_o   = ready_q;
  assign int_rst_o = ~run_q | pulse_q;

  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q && !ready_clr_i && !start_i) |=> ready_q); // R7
  AST_LAST_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv && last) |=> (!run_q && int_rst_o)); // R9
  AST_CONT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv && left_q == '0) |=> run_q); // R10
  AST_START_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (run_q && !ready_q && !int_rst_o)); // R2
endmodule

// File: rtl/incadc_accum.sv
module incadc_accum
  import incadc_pkg::*;
#(
  parameter int unsigned LOW_W    = 8,
  parameter int unsigned SAMP_W   = 8,
  parameter int unsigned SCALE_SH = SCALE_SH_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [SAMP_W-1:0]    samp_cnt_i,
  input  logic                 signed_i,
  input  logic                 az_off_i,
  input  logic                 gate_i,
  input  logic                 period_i,
  input  logic                 ready_clr_i,
  output logic [2*LOW_W-1:0]   result_o,
  output logic                 ready_o,
  output logic                 run_o,
  output logic                 int_rst_o,
  output logic                 az_o
);
  localparam int unsigned UP_W  = 2 * LOW_W;
  localparam int unsigned RES_W = 2 * LOW_W;

  logic             conv, run, int_rst;
  logic [LOW_W-1:0] low_v;
  logic [UP_W-1:0]  up_v, preset_v;
  logic [RES_W-1:0] res_v, result_q;

  // signed preset puts the most negative count in the word
  assign preset_v = (fmt_e'(signed_i) == FMT_SGN) ?
                    {{LOW_W{1'b1}}, 1'b1, {(LOW_W-1){1'b0}}} : '0;

  incadc_ctrl #(.SAMP_W(SAMP_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .samp_cnt_i  (samp_cnt_i),
    .period_i    (period_i),
    .ready_clr_i (ready_clr_i),
    .conv_o      (conv),
    .run_o       (run),
    .ready_o     (ready_o),
    .int_rst_o   (int_rst)
  );

  incadc_ext_cnt #(.LOW_W(LOW_W), .UP_W(UP_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (start_i | conv),
    .preset_i (preset_v),
    .cnt_en_i (run & gate_i & ~period_i),
    .low_o    (low_v),
    .up_o     (up_v)
  );

  incadc_fmt #(.LOW_W(LOW_W), .UP_W(UP_W), .RES_W(RES_W), .SCALE_SH(SCALE_SH)) u_fmt (
    .low_i    (low_v),
    .up_i     (up_v),
    .signed_i (signed_i),
    .res_o    (res_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   result_q <= '0;
    else if (conv) result_q <= res_v;
  end

  assign result_o  = result_q;
  assign run_o     = run;
  assign int_rst_o = int_rst;
  assign az_o      = az_off_i & int_rst;

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv |=> $stable(result_o)); // R7
  AST_IDLE_NOCOUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !start_i) |=> ($stable(low_v) && $stable(up_v))); // R3
endmodule

// File: tb/sim_incadc_accum.sv
module sim_incadc_accum;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  samp_cnt_i = '0;
  logic        signed_i = 1'b0;
  logic        az_off_i = 1'b1;
  logic        gate_i = 1'b0;
  logic        period_i = 1'b0;
  logic        ready_clr_i = 1'b0;
  logic [15:0] result_o;
  logic        ready_o, run_o, int_rst_o, az_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  incadc_accum u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .samp_cnt_i(samp_cnt_i),
    .signed_i(signed_i), .az_off_i(az_off_i), .gate_i(gate_i), .period_i(period_i),
    .ready_clr_i(ready_clr_i), .result_o(result_o), .ready_o(ready_o), .run_o(run_o),
    .int_rst_o(int_rst_o), .az_o(az_o)
  );

  function automatic logic [15:0] exp_res(int n, bit sg);
    logic [23:0] acc;
    logic ovf;
    acc = (sg ? 24'hFF8000 : 24'h000000) + 24'(n) + 24'd1;
    ovf = sg ? (!acc[23] && acc[15]) : acc[16];
    if (ovf) acc = sg ? 24'h007FFF : 24'h00FFFF;
    return acc[17:2];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(logic [7:0] k, bit sg);
    signed_i = sg; samp_cnt_i = k; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2 run", run_o, 1);
    chk("R2 ready", ready_o, 0);
    chk("R2 int_rst", int_rst_o, 0);
  endtask

  // count n ticks, then strobe with gate high (must not count); checks due one edge later
  task automatic do_conv(int n, bit rnd, bit last_one);
    int cnt = 0;
    while (cnt < n) begin
      gate_i = rnd ? 1'($urandom % 2) : 1'b1;
      if (gate_i) cnt++;
      @(negedge clk_i);
    end
    gate_i = 1'b1; period_i = 1'b1;
    @(negedge clk_i);
    gate_i = 1'b0; period_i = 1'b0;
    chk(signed_i ? "R5 result" : "R3 result", result_o, exp_res(n, signed_i));
    chk("R7 ready", ready_o, 1);
    chk("R8 int_rst pulse", int_rst_o, 1);
    chk("R8 az", az_o, az_off_i);
    @(negedge clk_i);
    if (!last_one) begin
      chk("R8 int_rst fall", int_rst_o, 0);
      chk("R10 run", run_o, 1);
    end
    chk("R7 ready sticky", ready_o, 1);
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R1 result", result_o, 0);
    chk("R1 int_rst", int_rst_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready", ready_o, 0);
    chk("R1 run", run_o, 0);
    chk("R1 int_rst", int_rst_o, 1);

    // unsigned, continuous, auto-zero follows reset
    az_off_i = 1'b1;
    do_start(8'd0, 1'b0);
    do_conv(0, 0, 0);
    do_conv(255, 0, 0);   // R4 boundaries
    do_conv(256, 0, 0);
    do_conv(511, 1, 0);
    do_conv(767, 0, 0);
    for (int i = 0; i < 6; i++) do_conv(int'($urandom % 400), 1, 0);
    ready_clr_i = 1'b1;
    @(negedge clk_i);
    ready_clr_i = 1'b0;
    chk("R11 clear", ready_o, 0);
    do_conv(3, 0, 0);
    chk("R10 still running", run_o, 1);

    // signed, auto-zero independent
    az_off_i = 1'b0;
    do_start(8'd0, 1'b1);
    do_conv(0, 0, 0);
    do_conv(1023, 0, 0);
    for (int i = 0; i < 5; i++) do_conv(int'($urandom % 400), 1, 0);

    // finite run of three
    do_start(8'd3, 1'b1);
    do_conv(10, 1, 0);
    do_conv(300, 1, 0);
    do_conv(77, 1, 1);
    chk("R9 stopped", run_o, 0);
    chk("R9 held in reset", int_rst_o, 1);
    repeat (3) @(negedge clk_i);
    chk("R9 still reset", int_rst_o, 1);
    ready_clr_i = 1'b1;
    @(negedge clk_i);
    ready_clr_i = 1'b0;
    gate_i = 1'b1; period_i = 1'b1;
    @(negedge clk_i);
    gate_i = 1'b0; period_i = 1'b0;
    @(negedge clk_i);
    chk("R11 idle strobe result", result_o, exp_res(77, 1'b1));
    chk("R11 idle strobe ready", ready_o, 0);
    chk("R3 idle run", run_o, 0);

    // overflow clamps
    do_start(8'd0, 1'b0);
    do_conv(65535, 0, 0);
    chk("R6 unsigned clamp", result_o, 16'h3FFF);
    do_start(8'd0, 1'b1);
    do_conv(65535, 0, 0);
    chk("R6 signed clamp", result_o, 16'h1FFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule